// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block collects the summary interrupt and summary halt lines of four leaf modules and folds them into one global interrupt and one global halt. The raw leaf lines are captured into two master status registers, one for interrupts and one for halts. Bit 0 of each belongs to module A, bit 1 to B, bit 2 to C and bit 3 to D. Each tree has its own four-bit enable mask. The two masked ORs are captured into a two-bit final status register. Each bit of that register then passes to an output only when its own single-bit global enable is set.

Every status register is non-sticky and read-only. It follows its sources one cycle later. Software clears an indication only by servicing the leaf that raised it. The aggregator holds no clear logic. The interrupt tree and the halt tree stay fully separate until the final register, so halts can act as a second priority level.

Software reaches the registers through a plain single-cycle register port. A write takes effect at the clock edge where the write strobe is high. Read data is combinational from the address. The port has no stall, so there is no back-pressure. There is no streaming data path, so no valid/ready handshake is used.

Top module: `irq_rollup`

## Requirements
- R1: The interrupt status register at 0x1000 holds the four leaf interrupt inputs in bits 3:0. Bit 0 is module A and bit 3 is module D. It shows the input values one clock edge after they are applied.
- R2: The halt status register at 0x1004 holds the four leaf halt inputs with the same bit layout and the same one-edge delay.
- R3: Status bits are non-sticky. A status bit returns to 0 one edge after its input drops, with no software action.
- R4: Writes to the status addresses 0x1000, 0x1004 and 0x1010 have no effect on what those addresses read.
- R5: The interrupt mask at 0x1008 and the halt mask at 0x100C are four bits wide, in bits 3:0, with 1 meaning enabled. They read back what was written, and bits 31:4 read 0.
- R6: The final status register at 0x1010 holds two bits. Bit 0 is the OR of (interrupt status AND interrupt mask). Bit 1 is the OR of (halt status AND halt mask). Both are captured one edge after the master status, so they lag a leaf input by two edges.
- R7: The global enable register at 0x1014 holds two bits. Bit 0 enables the global interrupt and bit 1 enables the global halt. Bits 31:2 read 0.
- R8: glb_irq_o equals final status bit 0 AND global enable bit 0. glb_halt_o equals final status bit 1 AND global enable bit 1. Both are combinational from those registers.
- R9: Reads of any address other than the six listed return 0. Misaligned addresses count as unmapped.
- R10: After reset every register reads 0 and both global outputs are 0.
- R11: The halt mask and halt inputs have no effect on the interrupt path, and the interrupt mask and interrupt inputs have no effect on the halt path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Write strobe, acts at the rising edge |
| reg_addr_i | input | 16 | Byte address for the read and the write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| leaf_irq_i | input | 4 | Leaf summary interrupts, bit 0 is module A |
| leaf_halt_i | input | 4 | Leaf summary halts, bit 0 is module A |
| glb_irq_o | output | 1 | Gated global interrupt |
| glb_halt_o | output | 1 | Gated global halt |

## Verification
A master status bit that sticks or lags shows up on the read port one edge after the leaf input moves. It also shows on the final status register and the global pins one edge after that. A mask or global-enable bit that holds the wrong value appears on the next read of its address. It also appears in the gating of the global pins in the same cycle. Trees that cross-couple, or a status register that accepts writes, show at the read port right after the offending stimulus.

// File: rtl/irq_rollup_pkg.sv
package irq_rollup_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned DATA_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_IRQ_STS  = 16'h0000;
  localparam logic [ADDR_W-1:0] OFS_HALT_STS = 16'h0004;
  localparam logic [ADDR_W-1:0] OFS_IRQ_EN   = 16'h0008;
  localparam logic [ADDR_W-1:0] OFS_HALT_EN  = 16'h000C;
  localparam logic [ADDR_W-1:0] OFS_FIN_STS  = 16'h0010;
  localparam logic [ADDR_W-1:0] OFS_GLB_EN   = 16'h0014;

  typedef struct packed {
    logic halt;
    logic irq;
  } glb_pair_t;
endpackage

// File: rtl/irq_sts_stage.sv
module irq_sts_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] sts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= src_i;
  end

  AST_STS_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sts_o == $past(src_i))); // R3
endmodule

// File: rtl/irq_mask_or.sv
module irq_mask_or #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] sts_i,
  input  logic [W-1:0] en_i,
  output logic         any_o
);
  logic [W-1:0] hit;
  for (genvar g = 0; g < W; g++) begin : g_lane
    assign hit[g] = sts_i[g] & en_i[g];
  end
  assign any_o = |hit;
endmodule

// File: rtl/irq_rollup_regs.sv
module irq_rollup_regs
  import irq_rollup_pkg::*;
#(
  parameter int unsigned         N      = NUM_SRC,
  parameter logic [ADDR_W-1:0]   BASE   = 16'h1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      irq_sts_i,
  input  logic [N-1:0]      halt_sts_i,
  input  glb_pair_t         fin_sts_i,
  output logic [N-1:0]      irq_en_o,
  output logic [N-1:0]      halt_en_o,
  output glb_pair_t         glb_en_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic sel_irq_sts, sel_halt_sts, sel_irq_en, sel_halt_en, sel_fin, sel_glb;

  assign sel_irq_sts  = (addr_i == BASE + OFS_IRQ_STS);
  assign sel_halt_sts = (addr_i == BASE + OFS_HALT_STS);
  assign sel_irq_en   = (addr_i == BASE + OFS_IRQ_EN);
  assign sel_halt_en  = (addr_i == BASE + OFS_HALT_EN);
  assign sel_fin      = (addr_i == BASE + OFS_FIN_STS);
  assign sel_glb      = (addr_i == BASE + OFS_GLB_EN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_o  <= '0;
      halt_en_o <= '0;
      glb_en_o  <= '0;
    end else if (wr_i) begin
      if (sel_irq_en)  irq_en_o  <= wdata_i[N-1:0];
      if (sel_halt_en) halt_en_o <= wdata_i[N-1:0];
      if (sel_glb)     glb_en_o  <= glb_pair_t'(wdata_i[1:0]);
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      sel_irq_sts:  rdata_o[N-1:0] = irq_sts_i;
      sel_halt_sts: rdata_o[N-1:0] = halt_sts_i;
      sel_irq_en:   rdata_o[N-1:0] = irq_en_o;
      sel_halt_en:  rdata_o[N-1:0] = halt_en_o;
      sel_fin:      rdata_o[1:0]   = fin_sts_i;
      sel_glb:      rdata_o[1:0]   = glb_en_o;
      default:      rdata_o        = '0;
    endcase
  end

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel_irq_en) |=> $stable(irq_en_o)); // R5
  AST_HALT_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel_halt_en) |=> $stable(halt_en_o)); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_irq_sts | sel_halt_sts | sel_irq_en | sel_halt_en | sel_fin | sel_glb)
      |-> (rdata_o == '0)); // R9
endmodule

// File: rtl/irq_rollup.sv
module irq_rollup
  import irq_rollup_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = 16'h1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NUM_SRC-1:0] leaf_irq_i,
  input  logic [NUM_SRC-1:0] leaf_halt_i,
  output logic              glb_irq_o,
  output logic              glb_halt_o
);
  localparam int unsigned N = NUM_SRC;

  logic [N-1:0] irq_sts, halt_sts, irq_en, halt_en;
  logic         m_irq, m_halt;
  glb_pair_t    fin_nxt, fin_sts, glb_en;

  irq_sts_stage #(.W(N)) u_irq_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(leaf_irq_i), .sts_o(irq_sts));
  irq_sts_stage #(.W(N)) u_halt_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(leaf_halt_i), .sts_o(halt_sts));

  irq_mask_or #(.W(N)) u_irq_or (
    .sts_i(irq_sts), .en_i(irq_en), .any_o(m_irq));
  irq_mask_or #(.W(N)) u_halt_or (
    .sts_i(halt_sts), .en_i(halt_en), .any_o(m_halt));

  assign fin_nxt.irq  = m_irq;
  assign fin_nxt.halt = m_halt;

  irq_sts_stage #(.W(2)) u_fin_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(fin_nxt), .sts_o(fin_sts));

  irq_rollup_regs #(.N(N), .BASE(BASE)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .irq_sts_i(irq_sts), .halt_sts_i(halt_sts),
    .fin_sts_i(fin_sts), .irq_en_o(irq_en), .halt_en_o(halt_en),
    .glb_en_o(glb_en), .rdata_o(reg_rdata_o));

  assign glb_irq_o  = fin_sts.irq  & glb_en.irq;
  assign glb_halt_o = fin_sts.halt & glb_en.halt;

  AST_IRQ_NEEDS_LEAF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_irq_o |-> $past(|leaf_irq_i, 2)); // R6
  AST_HALT_NEEDS_LEAF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_halt_o |-> $past(|leaf_halt_i, 2)); // R11
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_irq_o || glb_halt_o) |-> (glb_en != '0)); // R8
endmodule

// File: tb/irq_rollup_tb_top.sv
module irq_rollup_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  lirq = '0, lhalt = '0;
  logic        girq, ghalt;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  irq_rollup dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .leaf_irq_i(lirq),
    .leaf_halt_i(lhalt), .glb_irq_o(girq), .glb_halt_o(ghalt));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic drive(input logic [3:0] i, input logic [3:0] h, input int edges);
    @(negedge clk); lirq = i; lhalt = h;
    repeat (edges) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rd_chk("R10 irq sts", 16'h1000, 0);
    rd_chk("R10 halt sts", 16'h1004, 0);
    rd_chk("R10 irq en", 16'h1008, 0);
    rd_chk("R10 halt en", 16'h100C, 0);
    rd_chk("R10 fin sts", 16'h1010, 0);
    rd_chk("R10 glb en", 16'h1014, 0);
    check("R10 outs", {girq, ghalt}, 0);
  endtask

  task automatic t_follow;
    drive(4'b0101, 4'b1010, 1);
    addr = 16'h1000; #1 check("R1 irq sts one edge", rdata, 32'h5);
    addr = 16'h1004; #1 check("R2 halt sts one edge", rdata, 32'hA);
    drive(4'b1000, 4'b0001, 1);
    addr = 16'h1000; #1 check("R1 module D bit3", rdata, 32'h8);
    drive(4'b0000, 4'b0000, 1);
    addr = 16'h1000; #1 check("R3 irq sts clears", rdata, 0);
    addr = 16'h1004; #1 check("R3 halt sts clears", rdata, 0);
  endtask

  task automatic t_masks;
    wr_reg(16'h1008, 32'hFFFF_FFFF);
    rd_chk("R5 irq en width", 16'h1008, 32'hF);
    wr_reg(16'h100C, 32'h0000_0003);
    rd_chk("R5 halt en", 16'h100C, 32'h3);
    wr_reg(16'h1014, 32'hFFFF_FFFC);
    rd_chk("R7 glb en width", 16'h1014, 0);
    wr_reg(16'h1008, 0);
    wr_reg(16'h100C, 0);
  endtask

  task automatic t_readonly;
    wr_reg(16'h1000, 32'hF);
    rd_chk("R4 irq sts ro", 16'h1000, 0);
    wr_reg(16'h1004, 32'hF);
    rd_chk("R4 halt sts ro", 16'h1004, 0);
    wr_reg(16'h1010, 32'h3);
    rd_chk("R4 fin sts ro", 16'h1010, 0);
  endtask

  task automatic t_final;
    wr_reg(16'h1008, 32'h4);
    drive(4'b0100, 4'b0000, 1);
    addr = 16'h1010; #1 check("R6 fin lags two edges", rdata, 0);
    @(posedge clk); #1;
    check("R6 fin irq bit", rdata, 32'h1);
    check("R8 gated off", girq, 1'b0);
    wr_reg(16'h1014, 32'h1);
    check("R7 R8 glb irq on", girq, 1'b1);
    drive(4'b0011, 4'b0000, 2);
    addr = 16'h1010; #1 check("R6 masked sources", rdata, 0);
    check("R8 irq drops", girq, 1'b0);
    wr_reg(16'h1014, 0);
  endtask

  task automatic t_indep;
    wr_reg(16'h1008, 32'h0);
    wr_reg(16'h100C, 32'h8);
    wr_reg(16'h1014, 32'h3);
    drive(4'b1111, 4'b1000, 2);
    addr = 16'h1010; #1 check("R11 halt only", rdata, 32'h2);
    check("R11 irq unaffected", girq, 1'b0);
    check("R8 halt out", ghalt, 1'b1);
    wr_reg(16'h1014, 32'h1);
    check("R8 halt gated", ghalt, 1'b0);
    drive(0, 0, 2);
  endtask

  task automatic t_unmapped;
    rd_chk("R9 past end", 16'h1018, 0);
    rd_chk("R9 low", 16'h0000, 0);
    rd_chk("R9 misaligned", 16'h1009, 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_follow();
    t_masks();
    t_readonly();
    t_final();
    t_indep();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule